// File: doc/BRIEF.md
# Calendar Clock with Alarm

This block holds the time of day and a calendar (seconds, minutes, hours, day of week, day of month, month and two-digit year). It advances once for each one-second pulse from an external divider. Software reads and writes every field through a byte-wide register port. A control byte selects how values are encoded (BCD or plain binary) and how hours are shown (24-hour, or 12-hour with a PM flag in the top bit of the hours byte). The same control byte can freeze updates while software loads a new time.

Three alarm bytes are compared against seconds, minutes and hours. An alarm byte with both of its top two bits set matches any value of its field. When the fields after an update all match, the block raises a one-cycle alarm pulse. Fields are stored exactly as software wrote them, in the encoding currently selected. The block converts them to binary only to work out the next value, then stores the result in the same encoding.

Top module: `cal_clock`

## Requirements
- R1: After reset, seconds, minutes, hours, year and all three alarm bytes read 0x00. Day of week, day of month and month read 0x01. The control byte reads 0x02 (24-hour, BCD, running).
- R2: The register addresses are 0 seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hours, 5 hours alarm, 6 day of week, 7 day of month, 8 month, 9 year and 10 control. Each of these reads back the value written to it. The control byte keeps only bits 7, 2 and 1; its other bits read 0. Addresses 11 and above read 0x00, and writes to them change nothing.
- R3: On each update, seconds advance by one and wrap from 59 to 0. Minutes advance only on that wrap, and themselves wrap from 59 to 0.
- R4: In 24-hour mode (control bit 1 = 1), hours advance on the minutes wrap and run 0 to 23. The step from 23 to 0 carries into the day fields.
- R5: In 12-hour mode (control bit 1 = 0), the hours byte holds 1 to 12 in its low seven bits, with bit 7 = 1 for PM. The sequence is 12 AM, 1 AM to 11 AM, 12 PM, 1 PM to 11 PM, then 12 AM. The PM bit changes on the step from 11 to 12.
- R6: When control bit 2 = 1, every field is stored and counted in plain binary. When it is 0, every field is stored and counted in packed BCD (tens digit in bits 7:4, units digit in bits 3:0).
- R7: Day of week runs 1 to 7 and wraps to 1 on the day carry.
- R8: On the day carry, day of month wraps to 1 after the last day of the month. April, June, September and November have 30 days. February has 29 days when the year is a multiple of 4 and 28 otherwise. All other months have 31 days.
- R9: Month runs 1 to 12 and wraps to 1, carrying into the year. The year runs 0 to 99 and wraps to 0.
- R10: An alarm field matches when its alarm byte equals the field, or when the alarm byte has bits 7 and 6 both set. A byte with only one of those bits set must match exactly.
- R11: `alarm_hit` goes high for exactly one cycle, on the clock edge that applies an update, when all three fields of the updated time match.
- R12: While control bit 7 = 1, a `tick` changes no time field and raises no alarm. Counting resumes from the held value once the bit is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW (4) | Register address for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| alarm_hit | output | 1 | One-cycle alarm pulse |

## Verification
The bench builds the block with its default parameters: a 100-year span, leap years every 4 years and a 4-bit address. With these values it can visit every hour and minute pair at the seconds wrap, in both encodings, and every month of every year from 0 to 99 at the month-end carry. That covers each February leap decision and the year wrap from 99 to 0. It also steps all 24 hours in 12-hour mode in both encodings. It runs all 27 combinations of exact, wrong and wildcard for the three alarm bytes, plus alarm bytes with only one of the two top bits set.

// File: rtl/cal_clock_pkg.sv
package cal_clock_pkg;

  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] dom;
    logic [7:0] dow;
    logic [7:0] hr;
    logic [7:0] mn;
    logic [7:0] sc;
  } cal_time_t;

  // stored byte -> binary value
  function automatic logic [7:0] fld_dec(input logic [7:0] raw, input logic bin);
    logic [7:0] tens;
    tens = {4'd0, raw[7:4]};
    if (bin) return raw;
    return tens * 8'd10 + {4'd0, raw[3:0]};
  endfunction

  // binary value -> stored byte
  function automatic logic [7:0] fld_enc(input logic [7:0] val, input logic bin);
    logic [7:0] t;
    logic [7:0] o;
    t = val / 8'd10;
    o = val % 8'd10;
    if (bin) return val;
    return {t[3:0], o[3:0]};
  endfunction

  // hours byte (either format) -> 0..23
  function automatic logic [7:0] hr_to24(input logic [7:0] raw, input logic bin,
                                         input logic m24);
    logic [7:0] h;
    if (m24) return fld_dec(raw, bin);
    h = fld_dec({1'b0, raw[6:0]}, bin);
    if (h == 8'd12) h = 8'd0;
    if (raw[7]) h = h + 8'd12;
    return h;
  endfunction

  // 0..23 -> hours byte in the selected format
  function automatic logic [7:0] hr_from24(input logic [7:0] h, input logic bin,
                                           input logic m24);
    logic [7:0] h12;
    logic [7:0] r;
    if (m24) return fld_enc(h, bin);
    h12 = h % 8'd12;
    if (h12 == 8'd0) h12 = 8'd12;
    r = fld_enc(h12, bin);
    r[7] = (h >= 8'd12);
    return r;
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mo, input logic [7:0] yr,
                                           input int leap_period);
    case (mo)
      8'd2:                        return ((int'(yr) % leap_period) == 0) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:     return 8'd30;
      default:                     return 8'd31;
    endcase
  endfunction

endpackage

// File: rtl/cal_advance.sv
module cal_advance
  import cal_clock_pkg::*;
#(
  parameter int YEAR_SPAN   = 100,
  parameter int LEAP_PERIOD = 4
) (
  input  cal_time_t cur,
  input  logic      bin_mode,
  input  logic      mode24,
  output cal_time_t nxt,
  output logic      sec_wrap,
  output logic      min_wrap,
  output logic      hr_wrap,
  output logic      dom_wrap,
  output logic      mon_wrap
);

  localparam logic [7:0] YR_LAST = 8'(YEAR_SPAN - 1);

  logic [7:0] s, m, h, dw, d, mo, y, ml;

  always_comb begin
    s  = fld_dec(cur.sc, bin_mode);
    m  = fld_dec(cur.mn, bin_mode);
    h  = hr_to24(cur.hr, bin_mode, mode24);
    dw = fld_dec(cur.dow, bin_mode);
    d  = fld_dec(cur.dom, bin_mode);
    mo = fld_dec(cur.mon, bin_mode);
    y  = fld_dec(cur.yr, bin_mode);
    ml = month_len(mo, y, LEAP_PERIOD);

    sec_wrap = (s >= 8'd59);
    min_wrap = sec_wrap && (m >= 8'd59);
    hr_wrap  = min_wrap && (h >= 8'd23);
    dom_wrap = hr_wrap && (d >= ml);
    mon_wrap = dom_wrap && (mo >= 8'd12);

    // untouched fields keep their raw byte
    nxt    = cur;
    nxt.sc = fld_enc(sec_wrap ? 8'd0 : s + 8'd1, bin_mode);
    if (sec_wrap)
      nxt.mn = fld_enc((m >= 8'd59) ? 8'd0 : m + 8'd1, bin_mode);
    if (min_wrap)
      nxt.hr = hr_from24((h >= 8'd23) ? 8'd0 : h + 8'd1, bin_mode, mode24);
    if (hr_wrap) begin
      nxt.dow = fld_enc((dw >= 8'd7 || dw == 8'd0) ? 8'd1 : dw + 8'd1, bin_mode);
      nxt.dom = fld_enc((d >= ml) ? 8'd1 : d + 8'd1, bin_mode);
    end
    if (dom_wrap)
      nxt.mon = fld_enc((mo >= 8'd12) ? 8'd1 : mo + 8'd1, bin_mode);
    if (mon_wrap)
      nxt.yr = fld_enc((y >= YR_LAST) ? 8'd0 : y + 8'd1, bin_mode);
  end

endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_clock_pkg::*;
#(
  parameter int NUM_FIELDS = 3
) (
  input  cal_time_t                   t,
  input  logic [NUM_FIELDS-1:0][7:0]  al,
  output logic [NUM_FIELDS-1:0]       field_hit,
  output logic                        hit
);

  logic [2:0][7:0] cur_v;
  assign cur_v = {t.hr, t.mn, t.sc};

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    logic wild;
    assign wild         = (al[i][7:6] == 2'b11);
    assign field_hit[i] = wild || (al[i] == cur_v[i]);
  end

  assign hit = &field_hit;

endmodule

// File: rtl/cal_clock.sv
module cal_clock
  import cal_clock_pkg::*;
#(
  parameter int         AW          = 4,
  parameter int         YEAR_SPAN   = 100,
  parameter int         LEAP_PERIOD = 4,
  parameter logic [7:0] CTRL_RESET  = 8'h02
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data,
  output logic          alarm_hit
);

  localparam logic [AW-1:0] A_SEC    = AW'(0);
  localparam logic [AW-1:0] A_AL_SEC = AW'(1);
  localparam logic [AW-1:0] A_MIN    = AW'(2);
  localparam logic [AW-1:0] A_AL_MIN = AW'(3);
  localparam logic [AW-1:0] A_HR     = AW'(4);
  localparam logic [AW-1:0] A_AL_HR  = AW'(5);
  localparam logic [AW-1:0] A_DOW    = AW'(6);
  localparam logic [AW-1:0] A_DOM    = AW'(7);
  localparam logic [AW-1:0] A_MON    = AW'(8);
  localparam logic [AW-1:0] A_YR     = AW'(9);
  localparam logic [AW-1:0] A_CTRL   = AW'(10);
  localparam logic [7:0]    CTRL_MASK = 8'h86;

  localparam cal_time_t TIME_RESET = '{yr: 8'h00, mon: 8'h01, dom: 8'h01, dow: 8'h01,
                                       hr: 8'h00, mn: 8'h00, sc: 8'h00};

  cal_time_t       time_q, time_d, time_nx;
  logic [2:0][7:0] al_q, al_d;
  logic [7:0]      ctrl_q, ctrl_d;

  logic freeze, bin_mode, mode24;
  logic upd_evt;
  logic sec_wrap, min_wrap, hr_wrap, dom_wrap, mon_wrap;
  logic [2:0] field_hit;
  logic hit_nx;

  assign freeze   = ctrl_q[7];
  assign bin_mode = ctrl_q[2];
  assign mode24   = ctrl_q[1];
  assign upd_evt  = tick && !freeze;

  cal_advance #(
    .YEAR_SPAN  (YEAR_SPAN),
    .LEAP_PERIOD(LEAP_PERIOD)
  ) u_adv (
    .cur     (time_q),
    .bin_mode(bin_mode),
    .mode24  (mode24),
    .nxt     (time_nx),
    .sec_wrap(sec_wrap),
    .min_wrap(min_wrap),
    .hr_wrap (hr_wrap),
    .dom_wrap(dom_wrap),
    .mon_wrap(mon_wrap)
  );

  cal_alarm_match #(.NUM_FIELDS(3)) u_match (
    .t        (time_nx),
    .al       (al_q),
    .field_hit(field_hit),
    .hit      (hit_nx)
  );

  // next state: update first, then a write overrides its own field
  always_comb begin
    time_d = upd_evt ? time_nx : time_q;
    al_d   = al_q;
    ctrl_d = ctrl_q;
    if (wr_en) begin
      case (addr)
        A_SEC:    time_d.sc  = wr_data;
        A_AL_SEC: al_d[0]    = wr_data;
        A_MIN:    time_d.mn  = wr_data;
        A_AL_MIN: al_d[1]    = wr_data;
        A_HR:     time_d.hr  = wr_data;
        A_AL_HR:  al_d[2]    = wr_data;
        A_DOW:    time_d.dow = wr_data;
        A_DOM:    time_d.dom = wr_data;
        A_MON:    time_d.mon = wr_data;
        A_YR:     time_d.yr  = wr_data;
        A_CTRL:   ctrl_d     = wr_data & CTRL_MASK;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_q    <= TIME_RESET;
      al_q      <= '0;
      ctrl_q    <= CTRL_RESET & CTRL_MASK;
      alarm_hit <= 1'b0;
    end else begin
      time_q    <= time_d;
      al_q      <= al_d;
      ctrl_q    <= ctrl_d;
      alarm_hit <= upd_evt && hit_nx;
    end
  end

  always_comb begin
    case (addr)
      A_SEC:    rd_data = time_q.sc;
      A_AL_SEC: rd_data = al_q[0];
      A_MIN:    rd_data = time_q.mn;
      A_AL_MIN: rd_data = al_q[1];
      A_HR:     rd_data = time_q.hr;
      A_AL_HR:  rd_data = al_q[2];
      A_DOW:    rd_data = time_q.dow;
      A_DOM:    rd_data = time_q.dom;
      A_MON:    rd_data = time_q.mon;
      A_YR:     rd_data = time_q.yr;
      A_CTRL:   rd_data = ctrl_q;
      default:  rd_data = 8'h00;
    endcase
  end

endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk
  import cal_clock_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       upd_evt,
  input logic       wr_en,
  input logic       alarm_hit,
  input cal_time_t  time_q,
  input logic [7:0] al_sec,
  input logic       sec_wrap,
  input logic       min_wrap,
  input logic       hr_wrap,
  input logic       dom_wrap,
  input logic       mon_wrap
);

  a_r12_idle_holds_time: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_evt && !wr_en) |=> $stable(time_q));

  a_r3_sec_zero_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && !wr_en && sec_wrap) |=> (time_q.sc == 8'h00));

  a_r3_min_waits_for_sec: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && !wr_en && !sec_wrap) |=> $stable(time_q.mn));

  a_r4_hr_waits_for_min: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && !wr_en && !min_wrap) |=> $stable(time_q.hr));

  a_r7_dow_waits_for_day: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && !wr_en && !hr_wrap) |=> $stable(time_q.dow));

  a_r7_dow_stays_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && !wr_en && time_q.dow >= 8'd1 && time_q.dow <= 8'd7)
      |=> (time_q.dow >= 8'd1 && time_q.dow <= 8'd7));

  a_r8_mon_waits_for_dom: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && !wr_en && !dom_wrap) |=> $stable(time_q.mon));

  a_r9_yr_waits_for_mon: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && !wr_en && !mon_wrap) |=> $stable(time_q.yr));

  a_r11_hit_follows_update: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |-> $past(upd_evt));

  a_r11_hit_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_hit && !upd_evt) |=> !alarm_hit);

  a_r10_hit_sec_agrees: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_hit && !$past(wr_en)) |-> (al_sec[7:6] == 2'b11 || al_sec == time_q.sc));

endmodule

bind cal_clock cal_clock_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .upd_evt  (upd_evt),
  .wr_en    (wr_en),
  .alarm_hit(alarm_hit),
  .time_q   (time_q),
  .al_sec   (al_q[0]),
  .sec_wrap (sec_wrap),
  .min_wrap (min_wrap),
  .hr_wrap  (hr_wrap),
  .dom_wrap (dom_wrap),
  .mon_wrap (mon_wrap)
);

// File: tb/test_cal_clock.sv
`timescale 1ns/1ps
module test_cal_clock;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       alarm_hit;

  int checks = 0;
  int fails  = 0;
  logic hit_s, hit_after;

  always #10 clk = ~clk;

  cal_clock i_cal_clock (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .alarm_hit(alarm_hit)
  );

  localparam int SEC = 0, ASEC = 1, MIN = 2, AMIN = 3, HR = 4, AHR = 5;
  localparam int DOW = 6, DOM = 7, MON = 8, YR = 9, CTRL = 10;

  function automatic logic [7:0] enc(int v, bit bin);
    if (bin) return 8'(v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic logic [7:0] hbyte(int h24, bit bin, bit m24);
    int h12;
    if (m24) return enc(h24, bin);
    h12 = (h24 % 12 == 0) ? 12 : h24 % 12;
    return enc(h12, bin) | ((h24 >= 12) ? 8'h80 : 8'h00);
  endfunction

  function automatic int mdays(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    addr = 4'(a); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output logic [7:0] v);
    @(negedge clk);
    addr = 4'(a);
    #1 v = rd_data;
  endtask

  task automatic pulse;
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    hit_s = alarm_hit;
    @(negedge clk);
    hit_after = alarm_hit;
  endtask

  task automatic set_time(logic [7:0] h, logic [7:0] m, logic [7:0] s);
    wr(HR, h); wr(MIN, m); wr(SEC, s);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    for (int a = 0; a <= 10; a++) begin
      logic [7:0] e;
      rd(a, v);
      e = (a == DOW || a == DOM || a == MON) ? 8'h01 : (a == CTRL) ? 8'h02 : 8'h00;
      chk($sformatf("R1 reset addr %0d", a), v, e);
    end
    chk("R1 reset no alarm", {7'd0, alarm_hit}, 8'h00);

    // R2 register map readback
    for (int a = 0; a <= 9; a++) wr(a, 8'(8'h11 + a * 3));
    wr(CTRL, 8'hFF);
    wr(12, 8'h55);
    wr(15, 8'hAA);
    for (int a = 0; a <= 9; a++) begin
      rd(a, v);
      chk($sformatf("R2 readback addr %0d", a), v, 8'(8'h11 + a * 3));
    end
    rd(CTRL, v);  chk("R2 ctrl kept bits", v, 8'h86);
    rd(12, v);    chk("R2 unused addr 12", v, 8'h00);
    rd(15, v);    chk("R2 unused addr 15", v, 8'h00);

    // R3 R4 R6 every hour/minute at the seconds wrap, both encodings
    for (int b = 0; b < 2; b++) begin
      wr(CTRL, b ? 8'h06 : 8'h02);
      for (int h = 0; h < 24; h++) begin
        for (int m = 0; m < 60; m++) begin
          int tot;
          set_time(enc(h, b), enc(m, b), enc(59, b));
          pulse();
          tot = (h * 3600 + m * 60 + 60) % 86400;
          rd(SEC, v); chk("R3 sec wrap", v, enc(tot % 60, b));
          rd(MIN, v); chk("R3 min step", v, enc((tot / 60) % 60, b));
          rd(HR, v);  chk(b ? "R6 binary hour" : "R4 hour step", v, enc(tot / 3600, b));
        end
      end
      // R3 plain second step
      set_time(enc(5, b), enc(7, b), enc(19, b));
      pulse();
      rd(SEC, v); chk("R3 sec step", v, enc(20, b));
      rd(MIN, v); chk("R3 min held", v, enc(7, b));
    end

    // R5 12-hour sequence
    for (int b = 0; b < 2; b++) begin
      wr(CTRL, b ? 8'h04 : 8'h00);
      for (int h = 0; h < 24; h++) begin
        set_time(hbyte(h, b, 0), enc(59, b), enc(59, b));
        pulse();
        rd(HR, v);  chk("R5 12h hour", v, hbyte((h + 1) % 24, b, 0));
        rd(MIN, v); chk("R5 12h min", v, 8'h00);
      end
    end

    // R7 day of week
    wr(CTRL, 8'h02);
    for (int d = 1; d <= 7; d++) begin
      wr(DOW, 8'(d)); wr(DOM, 8'h01); wr(MON, 8'h01);
      set_time(8'h23, 8'h59, 8'h59);
      pulse();
      rd(DOW, v); chk("R7 dow", v, 8'((d == 7) ? 1 : d + 1));
      rd(DOM, v); chk("R7 dom step", v, 8'h02);
    end

    // R8 R9 month ends for every month of the year range
    for (int b = 0; b < 2; b++) begin
      wr(CTRL, b ? 8'h06 : 8'h02);
      for (int y = 0; y < (b ? 8 : 100); y++) begin
        for (int mo = 1; mo <= 12; mo++) begin
          int ml;
          ml = mdays(mo, y);
          wr(YR, enc(y, b)); wr(MON, enc(mo, b)); wr(DOM, enc(ml, b));
          set_time(enc(23, b), enc(59, b), enc(59, b));
          pulse();
          rd(DOM, v); chk("R8 month end", v, enc(1, b));
          rd(MON, v); chk("R9 month step", v, enc((mo == 12) ? 1 : mo + 1, b));
          rd(YR, v);  chk("R9 year", v, enc((mo == 12) ? (y + 1) % 100 : y, b));
        end
        // R8 February 28th
        wr(YR, enc(y, b)); wr(MON, enc(2, b)); wr(DOM, enc(28, b));
        set_time(enc(23, b), enc(59, b), enc(59, b));
        pulse();
        rd(DOM, v); chk("R8 feb 28 next", v, enc((y % 4 == 0) ? 29 : 1, b));
        rd(MON, v); chk("R8 feb month", v, enc((y % 4 == 0) ? 2 : 3, b));
      end
    end

    // R10 R11 alarm combinations: 0 exact, 1 wrong, 2 wildcard
    wr(CTRL, 8'h02);
    for (int code = 0; code < 27; code++) begin
      logic [7:0] tgt [3];
      logic exp_hit;
      tgt[0] = 8'h30; tgt[1] = 8'h20; tgt[2] = 8'h10;
      exp_hit = 1'b1;
      for (int i = 0; i < 3; i++) begin
        int c;
        logic [7:0] al;
        c = (code / ((i == 0) ? 1 : (i == 1) ? 3 : 9)) % 3;
        al = (c == 0) ? tgt[i] : (c == 1) ? tgt[i] + 8'h01 : 8'(8'hC0 + i * 8'h1F);
        if (c == 1) exp_hit = 1'b0;
        wr((i == 0) ? ASEC : (i == 1) ? AMIN : AHR, al);
      end
      set_time(8'h10, 8'h20, 8'h29);
      pulse();
      chk($sformatf("R10 alarm combo %0d", code), {7'd0, hit_s}, {7'd0, exp_hit});
      chk("R11 hit one cycle", {7'd0, hit_after}, 8'h00);
    end
    // R10 single top bit is not a wildcard
    wr(AMIN, 8'hFF); wr(AHR, 8'hC0);
    wr(ASEC, 8'h80);
    set_time(8'h10, 8'h20, 8'h29);
    pulse();
    chk("R10 bit7 only", {7'd0, hit_s}, 8'h00);
    wr(ASEC, 8'h40);
    set_time(8'h10, 8'h20, 8'h29);
    pulse();
    chk("R10 bit6 only", {7'd0, hit_s}, 8'h00);
    // R11 no hit without tick
    wr(ASEC, 8'hC0);
    repeat (3) @(negedge clk);
    chk("R11 no hit idle", {7'd0, alarm_hit}, 8'h00);

    // R12 freeze
    wr(CTRL, 8'h82);
    wr(SEC, 8'h45);
    pulse();
    rd(SEC, v); chk("R12 frozen sec", v, 8'h45);
    chk("R12 frozen no alarm", {7'd0, hit_s}, 8'h00);
    wr(CTRL, 8'h02);
    pulse();
    rd(SEC, v); chk("R12 resumed sec", v, 8'h46);
    chk("R12 resumed alarm", {7'd0, hit_s}, 8'h01);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule